// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 256K words by 16 bits with separate lower and upper byte enables. The host asks for one access at a time with a request/ready handshake. It gives a write flag, an 18-bit word address, write data and a two-bit lane mask. The sequencer turns each request into a timed series of chip enable, write enable, output enable and lane enable levels, and it drives or samples a split 16-bit data bus. A read hands back the sampled word with a one-cycle valid pulse.

Each phase length is a parameter given in nanoseconds. The block converts it into whole clock cycles, rounding up, with a floor of one cycle. The phases are address setup before the write strobe, the write strobe itself, read access and bus turnaround after a read. Every memory-side output comes straight from a flip-flop, so the strobes cannot glitch. Writes end on the rising edge of write enable while output enable stays high. Chip enable is high whenever the block is idle, which keeps the memory in standby.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, `ready` is 1, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are 1, and `dq_oe` and `rvalid` are 0.
- R2: A request is taken at a rising clock edge where `req` and `ready` are both 1. In the very next cycle `ready` is 0 and `mem_ce_n` is 0.
- R3: Lane mask bit 0 selects data bits 7:0 and drives `mem_lb_n` low. Bit 1 selects bits 15:8 and drives `mem_ub_n` low. A lane whose mask bit is 0 keeps its memory contents across a write.
- R4: A write holds `mem_we_n` high for AS cycles after acceptance, then low for exactly WP cycles, then high for one more cycle with `mem_ce_n` still low. `mem_oe_n` stays high throughout, and `ready` returns AS+WP+2 falling edges after acceptance.
- R5: While `mem_ce_n` stays low, `mem_addr` and the lane enables do not change. In a write, `dq_oe` is 1 and `dq_out` holds the request data when `mem_we_n` rises.
- R6: A read holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for AA cycles, then samples `dq_in`. `rvalid` is high for exactly one cycle, visible AA+1 falling edges after acceptance. In `rdata`, lanes whose mask bit is 0 read as zero.
- R7: After a read, `ready` stays low for TA cycles after `mem_oe_n` rises. `dq_oe` is never 1 while `mem_oe_n` is low, nor in the cycle right after.
- R8: Each phase length in cycles is max(1, ceil(time_ns / CLK_NS)).
- R9: `mem_ce_n` is high in every cycle where `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask: bit 0 low byte, bit 1 high byte |
| ready | output | 1 | Block can accept a request |
| rdata | output | 16 | Read word, lanes masked |
| rvalid | output | 1 | One-cycle read data strobe |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| dq_out | output | 16 | Data toward the memory |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 16 | Data from the memory bus |

## Verification
Some properties are checked by assertions on every cycle. They cover standby while ready, the exclusion of write enable from output enable, no bus drive during or just after a read, a steady address and lane enables while the chip is selected, the single-cycle read strobe, and the state at the rising edge of write enable. Other behaviour only shows up in the bench's scenarios against a behavioural memory. That covers the exact phase lengths, read and write latency, the effect of lane masking on stored and returned data, and the gap between a read and the next write.

// File: rtl/asram_pkg.sv
package asram_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSET,
    PH_WPUL,
    PH_WHLD,
    PH_RACC,
    PH_TURN
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic lanes_on;
    logic drive;
    logic ready;
  } ctl_t;

  // Cycles for a timing figure: round up, never below one.
  function automatic int unsigned phase_cycles(int unsigned t_ns, int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  // Memory-side levels that belong to each phase.
  function automatic ctl_t phase_ctl(phase_e p);
    ctl_t c;
    c = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, lanes_on: 1'b0, drive: 1'b0, ready: 1'b1};
    case (p)
      PH_WSET, PH_WHLD: begin
        c.ce_n = 1'b0; c.lanes_on = 1'b1; c.drive = 1'b1; c.ready = 1'b0;
      end
      PH_WPUL: begin
        c.ce_n = 1'b0; c.we_n = 1'b0; c.lanes_on = 1'b1; c.drive = 1'b1; c.ready = 1'b0;
      end
      PH_RACC: begin
        c.ce_n = 1'b0; c.oe_n = 1'b0; c.lanes_on = 1'b1; c.ready = 1'b0;
      end
      PH_TURN: c.ready = 1'b0;
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= len - W'(1);
    else if (cnt != '0)     cnt <= cnt - W'(1);
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/asram_dbus.sv
module asram_dbus
  import asram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_w,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cap,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dq_out <= '0;
    else if (load_w) dq_out <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= cap;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rdata[g*8 +: 8] <= '0;
      else if (cap) rdata[g*8 +: 8] <= mask[g] ? dq_in[g*8 +: 8] : 8'h00;
    end
  end

  // R6: the read strobe never stretches past one cycle
  assert_rvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned CLK_NS  = 20,
  parameter int unsigned T_AS_NS = 0,
  parameter int unsigned T_WP_NS = 7,
  parameter int unsigned T_AA_NS = 12,
  parameter int unsigned T_TA_NS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int unsigned AS_CYC  = phase_cycles(T_AS_NS, CLK_NS);
  localparam int unsigned WP_CYC  = phase_cycles(T_WP_NS, CLK_NS);
  localparam int unsigned AA_CYC  = phase_cycles(T_AA_NS, CLK_NS);
  localparam int unsigned TA_CYC  = phase_cycles(T_TA_NS, CLK_NS);
  localparam int unsigned MAX_A   = (AS_CYC > WP_CYC) ? AS_CYC : WP_CYC;
  localparam int unsigned MAX_B   = (AA_CYC > TA_CYC) ? AA_CYC : TA_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  phase_e            ph, ph_nx;
  ctl_t              ctl_nx;
  logic              acc_fire;
  logic              phase_last;
  logic              phase_load;
  logic              read_cap;
  logic [CNT_W-1:0]  len_nx;
  logic [LANES-1:0]  lat_mask;
  logic [LANES-1:0]  mask_sel;
  logic [LANES-1:0]  lane_n;

  function automatic logic [CNT_W-1:0] phase_len(phase_e p);
    case (p)
      PH_WSET: return CNT_W'(AS_CYC);
      PH_WPUL: return CNT_W'(WP_CYC);
      PH_RACC: return CNT_W'(AA_CYC);
      PH_TURN: return CNT_W'(TA_CYC);
      default: return CNT_W'(1);
    endcase
  endfunction

  assign acc_fire = req && ready;
  assign read_cap = (ph == PH_RACC) && phase_last;

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_IDLE: if (acc_fire)   ph_nx = req_we ? PH_WSET : PH_RACC;
      PH_WSET: if (phase_last) ph_nx = PH_WPUL;
      PH_WPUL: if (phase_last) ph_nx = PH_WHLD;
      PH_WHLD:                 ph_nx = PH_IDLE;
      PH_RACC: if (phase_last) ph_nx = PH_TURN;
      PH_TURN: if (phase_last) ph_nx = PH_IDLE;
      default:                 ph_nx = PH_IDLE;
    endcase
  end

  assign phase_load = (ph_nx != ph);
  assign len_nx     = phase_len(ph_nx);
  assign ctl_nx     = phase_ctl(ph_nx);
  assign mask_sel   = acc_fire ? req_mask : lat_mask;

  asram_timer #(.W(CNT_W)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (phase_load),
    .len   (len_nx),
    .last  (phase_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      dq_oe    <= 1'b0;
      ready    <= 1'b1;
      lane_n   <= '1;
    end else begin
      ph       <= ph_nx;
      mem_ce_n <= ctl_nx.ce_n;
      mem_we_n <= ctl_nx.we_n;
      mem_oe_n <= ctl_nx.oe_n;
      dq_oe    <= ctl_nx.drive;
      ready    <= ctl_nx.ready;
      lane_n   <= ctl_nx.lanes_on ? ~mask_sel : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      lat_mask <= '0;
    end else if (acc_fire) begin
      mem_addr <= req_addr;
      lat_mask <= req_mask;
    end
  end

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[1];

  asram_dbus dbus_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_w (acc_fire && req_we),
    .wdata  (req_wdata),
    .cap    (read_cap),
    .mask   (lat_mask),
    .dq_in  (dq_in),
    .dq_out (dq_out),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  // R9 / R1: idle means standby and a quiet bus
  assert_idle_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !dq_oe));

  // R2: the cycle after acceptance is busy and selected
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (!ready && !mem_ce_n));

  // R4: write strobe never overlaps output enable and always has the chip selected
  assert_we_excl_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && dq_oe));

  // R4 / R5: at the write-ending edge chip is still selected and data still driven
  assert_we_rise_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && dq_oe));

  // R5: address and lane enables stay put while selected
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n})));

  // R7: no drive while the memory may own the bus
  assert_no_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || $past(!mem_oe_n)) |-> !dq_oe);

endmodule

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;

  localparam int CLK_NS = 20;
  localparam int AS_NS = 0, WP_NS = 50, AA_NS = 45, TA_NS = 30;

  function automatic int exp_cyc(int ns);
    int q;
    q = ns / CLK_NS;
    if ((ns % CLK_NS) != 0) q = q + 1;
    if (q == 0) q = 1;
    return q;
  endfunction

  localparam int AS_E = exp_cyc(AS_NS);
  localparam int WP_E = exp_cyc(WP_NS);
  localparam int AA_E = exp_cyc(AA_NS);
  localparam int TA_E = exp_cyc(TA_NS);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        ready, rvalid, ce_n, we_n, oe_n, lb_n, ub_n, dq_oe;
  logic [15:0] rdata, dq_out, dq_in;
  logic [17:0] mem_addr;

  int checks = 0, bad = 0;
  bit done = 0;
  logic [15:0] mem [64];
  logic [15:0] exp_q [$];

  always #(CLK_NS/2) clk = ~clk;

  asram_ctrl #(.CLK_NS(CLK_NS), .T_AS_NS(AS_NS), .T_WP_NS(WP_NS),
               .T_AA_NS(AA_NS), .T_TA_NS(TA_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .ready(ready), .rdata(rdata),
    .rvalid(rvalid), .mem_addr(mem_addr), .mem_ce_n(ce_n), .mem_we_n(we_n),
    .mem_oe_n(oe_n), .mem_lb_n(lb_n), .mem_ub_n(ub_n), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // behavioural memory; undriven lanes float to a stray pattern
  wire sram_drv = !ce_n && !oe_n && we_n;
  assign dq_in[7:0]  = (sram_drv && !lb_n) ? mem[mem_addr[5:0]][7:0]  : 8'hA5;
  assign dq_in[15:8] = (sram_drv && !ub_n) ? mem[mem_addr[5:0]][15:8] : 8'hA5;

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, expv);
    end
  endtask

  always @(posedge we_n) begin
    if (rst_n === 1'b1 && ce_n === 1'b0) begin
      chk(dq_oe === 1'b1, "R5 data driven at write end", {31'd0, dq_oe}, 32'd1);
      if (!lb_n) mem[mem_addr[5:0]][7:0]  = dq_out[7:0];
      if (!ub_n) mem[mem_addr[5:0]][15:8] = dq_out[15:8];
    end
  end

  // monitor: scoreboard plus per-cycle bus rules
  int we_run = 0, oe_hi = 0;
  bit seen_read = 0, prev_sel = 0;
  logic [17:0] prev_addr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected rvalid", {16'd0, rdata}, 32'd0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rdata === e, "R6 R3 read data", {16'd0, rdata}, {16'd0, e});
        end
      end
      if (!we_n) begin
        we_run++;
        if (oe_n !== 1'b1) chk(0, "R4 oe_n high during write", {31'd0, oe_n}, 32'd1);
      end else if (we_run != 0) begin
        chk(we_run == WP_E, "R4 R8 write pulse cycles", we_run, WP_E);
        we_run = 0;
      end
      if (sram_drv && dq_oe) chk(0, "R7 bus contention", 32'd1, 32'd0);
      if (ready && !ce_n) chk(0, "R9 standby while ready", {31'd0, ce_n}, 32'd1);
      if (!ce_n && prev_sel && mem_addr !== prev_addr)
        chk(0, "R5 address moved while selected", {14'd0, mem_addr}, {14'd0, prev_addr});
      prev_sel  = !ce_n;
      prev_addr = mem_addr;
      if (!oe_n) begin seen_read = 1; oe_hi = 0; end
      else begin
        if (dq_oe && seen_read) begin
          chk(oe_hi >= TA_E + 1, "R7 turnaround gap", oe_hi, TA_E + 1);
          seen_read = 0;
        end
        oe_hi++;
      end
    end
  end

  task automatic do_write(logic [17:0] a, logic [15:0] d, logic [1:0] m);
    int n;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; req_we = 1; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req = 0;
    n = 1;
    chk(!ready && !ce_n, "R2 busy after accept", {30'd0, ready, ce_n}, 32'd0);
    chk({ub_n, lb_n} == ~m, "R3 lane enables", {30'd0, ub_n, lb_n}, {30'd0, ~m});
    while (!ready) begin @(negedge clk); n++; end
    chk(n == AS_E + WP_E + 2, "R4 write completion", n, AS_E + WP_E + 2);
  endtask

  task automatic do_read(logic [17:0] a, logic [1:0] m, logic [15:0] e);
    int n;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; req_we = 0; req_addr = a; req_mask = m;
    exp_q.push_back(e);
    @(negedge clk);
    req = 0;
    n = 1;
    chk(!ready && !ce_n && !oe_n && we_n, "R2 R6 read selected",
        {28'd0, ready, ce_n, oe_n, we_n}, 32'd1);
    while (!rvalid) begin @(negedge clk); n++; end
    chk(n == AA_E + 1, "R6 R8 read latency", n, AA_E + 1);
    while (!ready) begin @(negedge clk); n++; end
    chk(n == AA_E + TA_E + 1, "R7 ready after turnaround", n, AA_E + TA_E + 1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ready && ce_n && we_n && oe_n && lb_n && ub_n && !dq_oe && !rvalid,
        "R1 reset state", {24'd0, ready, ce_n, we_n, oe_n, lb_n, ub_n, dq_oe, rvalid},
        32'hFC);
    do_write(18'h00011, 16'h1234, 2'b11);
    do_read (18'h00011, 2'b11, 16'h1234);
    do_write(18'h3FF22, 16'hBEEF, 2'b11);
    do_write(18'h3FF22, 16'h00CD, 2'b01);          // R3 low lane only
    do_read (18'h3FF22, 2'b11, 16'hBECD);
    do_write(18'h3FF22, 16'h5A77, 2'b10);          // R3 high lane only
    do_read (18'h3FF22, 2'b01, 16'h00CD);          // R6 masked lane zero
    do_read (18'h3FF22, 2'b10, 16'h5A00);
    do_read (18'h20005, 2'b11, 16'h0000);
    do_write(18'h00011, 16'hC3C3, 2'b00);          // R3 no lane: unchanged
    do_read (18'h00011, 2'b11, 16'h1234);
    @(negedge clk);
    chk(ready && ce_n && !dq_oe, "R1 R9 idle after traffic",
        {29'd0, ready, ce_n, dq_oe}, 32'd6);
    chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
    done = 1;
    finish_run();
  end

endmodule